// File: doc/BRIEF.md
# Strided Interleave Address Generator

This block walks the address pairs of an interleaved block copy between main memory and a scratchpad memory. One transfer moves a given number of 16-byte quadwords. On the main-memory side the walk reads or writes a burst of quadwords, then jumps over a gap of quadwords. It repeats this burst-and-gap pattern until the total count is used up. The scratchpad side is walked without gaps. A direction input chooses whether the scratchpad is the source or the destination. The gap always applies to the main-memory address.

The block raises `out_valid` with one source/destination address pair per quadword. Each pair is held until the consumer accepts it with `out_ready`. After the final quadword has been accepted, `done` is raised for a single cycle. The consumer moves the data and handles the bus. This block only generates addresses.

The burst length, gap length, direction and both base addresses are captured when the transfer starts. A burst length of zero means the whole count is one burst. The final burst is cut short to the quadwords that remain.

Top module: `stride_addr_gen`

## Requirements
- R1: After a synchronous reset, `out_valid` and `done` are low.
- R2: While a transfer runs, `out_valid` stays high and each pair is held stable until `out_ready` is seen high. Inside a burst, both addresses advance by 16 after each accepted quadword.
- R3: Each burst covers min(`burst_qwc`, quadwords remaining). When fewer quadwords remain than `burst_qwc`, the last burst is shortened.
- R4: A `burst_qwc` of zero makes the whole `total_qwc` one contiguous burst on both sides.
- R5: At the end of a burst, the main-memory address for the next burst is the previous burst's start plus (`skip_qwc` + burst)×16. The scratchpad address stays contiguous, one step of 16 per quadword. A `skip_qwc` of zero gives a contiguous walk.
- R6: With `dir_sel`=0, `src_addr` is the main-memory address and `dst_addr` is the scratchpad address. With `dir_sel`=1, the two are swapped.
- R7: `done` is high for exactly the one cycle after the last quadword is accepted, and `out_valid` is low in that cycle.
- R8: A `start` with `total_qwc`=0 produces no valid pair and raises `done` in the next cycle.
- R9: A `start` that arrives while a transfer runs is ignored. Changes to the configuration inputs after a transfer has been accepted do not alter that transfer.
- R10: A `start` seen in the same cycle as `done` begins a new transfer, and `out_valid` rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| dir_sel | input | 1 | 0: memory to scratchpad, 1: scratchpad to memory |
| total_qwc | input | CNT_W | Total quadwords to move |
| burst_qwc | input | CNT_W | Quadwords per burst on the memory side (0 = all) |
| skip_qwc | input | CNT_W | Quadwords skipped after each memory burst |
| mem_base | input | ADDR_W | Main-memory start byte address |
| spad_base | input | ADDR_W | Scratchpad start byte address |
| out_valid | output | 1 | An address pair is offered |
| out_ready | input | 1 | Consumer accepts the offered pair |
| src_addr | output | ADDR_W | Source byte address of the current quadword |
| dst_addr | output | ADDR_W | Destination byte address of the current quadword |
| done | output | 1 | One-cycle pulse after the last accepted quadword |

## Verification
Two events can fall in the same cycle: the end-of-transfer `done` pulse and the acceptance of a fresh `start`. The bench provokes this by holding `start` high through a whole transfer, which also shows that starts during a run are ignored. It then swaps the configuration in the cycle where `done` is seen. A behavioural model in the bench judges the outcome by predicting the new transfer's first pair in the very next cycle. The model also predicts the burst and gap boundaries, which are exercised while `out_ready` stalls at random.

// File: rtl/stride_pkg.sv
package stride_pkg;

    // bytes per quadword and the shift that goes with it
    localparam int QW_BYTES = 16;
    localparam int QW_SHIFT = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef enum logic {
        DIR_MEM_TO_SPAD = 1'b0,
        DIR_SPAD_TO_MEM = 1'b1
    } dir_e;

    // command from the sequencer to the address walker
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_UNIT = 2'd2,
        STEP_SKIP = 2'd3
    } step_e;

endpackage

// File: rtl/stride_qw_counter.sv
module stride_qw_counter
    import stride_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             load,
    input  logic             accept,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] burst,
    output logic             last_qw,
    output logic             burst_end
);

    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] burst_q;
    logic [CNT_W-1:0] rem_after;

    // burst length for the quadwords still to go
    function automatic logic [CNT_W-1:0] pick_burst(
        input logic [CNT_W-1:0] cfg,
        input logic [CNT_W-1:0] rem
    );
        return ((cfg == '0) || (cfg > rem)) ? rem : cfg;
    endfunction

    assign rem_after = rem_q - CNT_W'(1);
    assign last_qw   = (rem_q == CNT_W'(1));
    assign burst_end = (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            left_q  <= '0;
            burst_q <= '0;
        end else if (load) begin
            rem_q   <= total;
            burst_q <= burst;
            left_q  <= pick_burst(burst, total);
        end else if (accept) begin
            rem_q <= rem_after;
            if (burst_end) begin
                left_q <= pick_burst(burst_q, rem_after);
            end else begin
                left_q <= left_q - CNT_W'(1);
            end
        end
    end

    // a running burst never exceeds its configured size or the quadwords left
    assert_burst_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (active && burst_q != '0) |-> (left_q <= burst_q && left_q <= rem_q && left_q != '0));

    // with zero burst size the whole remainder is one burst
    assert_whole_burst_R4: assert property (@(posedge clk) disable iff (rst)
        (active && burst_q == '0) |-> (left_q == rem_q));

endmodule

// File: rtl/stride_addr_walker.sv
module stride_addr_walker
    import stride_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] spad_base,
    input  logic [CNT_W-1:0]  skip,
    output logic [ADDR_W-1:0] mem_ptr,
    output logic [ADDR_W-1:0] spad_ptr
);

    localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(QW_BYTES);

    logic [CNT_W-1:0]  skip_q;
    logic [ADDR_W-1:0] jump;

    // byte distance from the last quadword of a burst to the first of the next
    assign jump = (ADDR_W'(skip_q) + ADDR_W'(1)) << QW_SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ptr  <= '0;
            spad_ptr <= '0;
            skip_q   <= '0;
        end else begin
            unique case (step)
                STEP_LOAD: begin
                    mem_ptr  <= mem_base;
                    spad_ptr <= spad_base;
                    skip_q   <= skip;
                end
                STEP_UNIT: begin
                    mem_ptr  <= mem_ptr + UNIT_STEP;
                    spad_ptr <= spad_ptr + UNIT_STEP;
                end
                STEP_SKIP: begin
                    mem_ptr  <= mem_ptr + jump;
                    spad_ptr <= spad_ptr + UNIT_STEP;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
    import stride_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_sel,
    input  logic [CNT_W-1:0]  total_qwc,
    input  logic [CNT_W-1:0]  burst_qwc,
    input  logic [CNT_W-1:0]  skip_qwc,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] spad_base,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              done
);

    phase_e            phase_q;
    dir_e              dir_q;
    logic              done_q;
    logic              running;
    logic              accept;
    logic              launch;
    logic              empty_start;
    logic              last_qw;
    logic              burst_end;
    step_e             step;
    logic [ADDR_W-1:0] mem_ptr;
    logic [ADDR_W-1:0] spad_ptr;

    assign running     = (phase_q == PH_RUN);
    assign accept      = running && out_ready;
    assign launch      = (phase_q == PH_IDLE) && start && (total_qwc != '0);
    assign empty_start = (phase_q == PH_IDLE) && start && (total_qwc == '0);

    always_comb begin
        step = STEP_HOLD;
        if (launch) begin
            step = STEP_LOAD;
        end else if (accept && !last_qw) begin
            step = burst_end ? STEP_SKIP : STEP_UNIT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dir_q   <= DIR_MEM_TO_SPAD;
            done_q  <= 1'b0;
        end else begin
            done_q <= (accept && last_qw) || empty_start;
            if (launch) begin
                phase_q <= PH_RUN;
                dir_q   <= dir_e'(dir_sel);
            end else if (accept && last_qw) begin
                phase_q <= PH_IDLE;
            end
        end
    end

    stride_qw_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk       (clk),
        .rst       (rst),
        .active    (running),
        .load      (launch),
        .accept    (accept),
        .total     (total_qwc),
        .burst     (burst_qwc),
        .last_qw   (last_qw),
        .burst_end (burst_end)
    );

    stride_addr_walker #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_walker (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .mem_base  (mem_base),
        .spad_base (spad_base),
        .skip      (skip_qwc),
        .mem_ptr   (mem_ptr),
        .spad_ptr  (spad_ptr)
    );

    assign out_valid = running;
    assign done      = done_q;
    assign src_addr  = (dir_q == DIR_SPAD_TO_MEM) ? spad_ptr : mem_ptr;
    assign dst_addr  = (dir_q == DIR_SPAD_TO_MEM) ? mem_ptr  : spad_ptr;

    // offered pair is held while the consumer stalls
    assert_hold_pair_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(src_addr) && $stable(dst_addr)));

    // scratchpad side advances one quadword per acceptance inside a transfer
    assert_spad_contig_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !last_qw) |=> (spad_ptr == $past(spad_ptr) + ADDR_W'(QW_BYTES)));

    // memory side jumps over the gap at a burst boundary
    assert_mem_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !last_qw && burst_end)
        |=> (mem_ptr == $past(mem_ptr) + ((ADDR_W'($past(skip_qwc == skip_qwc) ? u_walker.skip_q : u_walker.skip_q) + ADDR_W'(1)) << QW_SHIFT)));

    // done follows the final acceptance and is never shown with a valid pair
    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && last_qw) |=> (done && !out_valid));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

    // an empty transfer only pulses done
    assert_empty_start_R8: assert property (@(posedge clk) disable iff (rst)
        empty_start |=> (done && !out_valid));

endmodule

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int WATCHDOG = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              dir_sel = 1'b0;
    logic [CNT_W-1:0]  total_qwc = '0;
    logic [CNT_W-1:0]  burst_qwc = '0;
    logic [CNT_W-1:0]  skip_qwc = '0;
    logic [ADDR_W-1:0] mem_base = '0;
    logic [ADDR_W-1:0] spad_base = '0;
    logic              out_ready = 1'b1;
    logic              out_valid;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic              done;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    rand_ready = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // reference model state
    logic [63:0] exp_q[$];
    bit          m_run = 1'b0;
    bit          m_done = 1'b0;
    bit          m_dir = 1'b0;
    bit          m_dnext;
    int          b_rem, b_cnt, b_tq;
    logic [ADDR_W-1:0] b_mem, b_spad;

    always #10 clk = ~clk;

    stride_addr_gen #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_stride_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dir_sel   (dir_sel),
        .total_qwc (total_qwc),
        .burst_qwc (burst_qwc),
        .skip_qwc  (skip_qwc),
        .mem_base  (mem_base),
        .spad_base (spad_base),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // behavioural model: expected pair list built from the burst/gap rule
    always @(posedge clk) begin
        cyc++;
        m_dnext = 1'b0;
        if (rst) begin
            exp_q.delete();
            m_run = 1'b0;
        end else if (m_run) begin
            if (out_ready) begin
                void'(exp_q.pop_front());
                if (exp_q.size() == 0) begin
                    m_run   = 1'b0;
                    m_dnext = 1'b1;
                end
            end
        end else if (start) begin
            if (total_qwc == '0) begin
                m_dnext = 1'b1;
            end else begin
                b_rem  = int'(total_qwc);
                b_tq   = (burst_qwc == '0) ? b_rem : int'(burst_qwc);
                b_mem  = mem_base;
                b_spad = spad_base;
                while (b_rem > 0) begin
                    b_cnt = (b_tq < b_rem) ? b_tq : b_rem;
                    for (int i = 0; i < b_cnt; i++) begin
                        exp_q.push_back({b_mem + ADDR_W'(16 * i), b_spad + ADDR_W'(16 * i)});
                    end
                    b_spad = b_spad + ADDR_W'(16 * b_cnt);
                    b_mem  = b_mem + ADDR_W'(16 * (int'(skip_qwc) + b_cnt));
                    b_rem  = b_rem - b_cnt;
                end
                m_run = 1'b1;
                m_dir = dir_sel;
            end
        end
        m_done = m_dnext;
    end

    // compare on every cycle, then drive the ready line
    always @(negedge clk) begin
        if (cyc >= 2) begin
            chk(out_valid === m_run, cur_req, "out_valid", 64'(out_valid), 64'(m_run));
            chk(done === m_done, cur_req, "done (R7)", 64'(done), 64'(m_done));
            if (m_run && exp_q.size() > 0) begin
                // R6: memory address is the source when dir is 0, destination when 1
                chk(src_addr === (m_dir ? exp_q[0][31:0] : exp_q[0][63:32]), cur_req,
                    "src_addr (R6)", 64'(src_addr), 64'(m_dir ? exp_q[0][31:0] : exp_q[0][63:32]));
                chk(dst_addr === (m_dir ? exp_q[0][63:32] : exp_q[0][31:0]), cur_req,
                    "dst_addr (R6)", 64'(dst_addr), 64'(m_dir ? exp_q[0][63:32] : exp_q[0][31:0]));
            end
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = rand_ready ? (lfsr[0] | lfsr[5]) : 1'b1;
    end

    task automatic setup(input int tot, input int tq, input int sq, input bit dir,
                         input logic [ADDR_W-1:0] mb, input logic [ADDR_W-1:0] sb);
        total_qwc = CNT_W'(tot);
        burst_qwc = CNT_W'(tq);
        skip_qwc  = CNT_W'(sq);
        dir_sel   = dir;
        mem_base  = mb;
        spad_base = sb;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (done !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, req, "done reached", 64'(done), 64'd1);
    endtask

    task automatic run_xfer(input string req, input int tot, input int tq, input int sq,
                            input bit dir, input logic [ADDR_W-1:0] mb,
                            input logic [ADDR_W-1:0] sb, input bit rr);
        @(negedge clk);
        cur_req    = req;
        rand_ready = rr;
        setup(tot, tq, sq, dir, mb, sb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid === 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        chk(done === 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1", "idle after reset", 64'(out_valid), 64'd0);

        // R3 / R5: bursts of 3, gap of 2, short final burst
        run_xfer("R3", 10, 3, 2, 1'b0, 32'h0010_0000, 32'h7000_0000, 1'b0);
        // R3: burst size larger than the count
        run_xfer("R3", 4, 9, 3, 1'b0, 32'h0002_0000, 32'h7000_0100, 1'b1);
        // R4: zero burst size, contiguous walk despite a gap value
        run_xfer("R4", 7, 0, 5, 1'b0, 32'h0003_0000, 32'h7000_0200, 1'b1);
        // R5: zero gap gives contiguous memory walk
        run_xfer("R5", 8, 2, 0, 1'b1, 32'h0004_0000, 32'h7000_0300, 1'b0);
        // R2 / R6: reversed direction with random stalls
        run_xfer("R2", 11, 4, 1, 1'b1, 32'h0005_0000, 32'h7000_0400, 1'b1);
        run_xfer("R6", 5, 2, 3, 1'b1, 32'h0006_0000, 32'h7000_0500, 1'b1);
        // R5: single-quadword bursts with wide gap
        run_xfer("R5", 6, 1, 7, 1'b0, 32'h0007_0000, 32'h7000_0600, 1'b1);
        // R8: empty transfer
        run_xfer("R8", 0, 3, 2, 1'b0, 32'h0008_0000, 32'h7000_0700, 1'b0);

        // R9: start and configuration changes during a run are ignored
        @(negedge clk);
        cur_req    = "R9";
        rand_ready = 1'b1;
        setup(9, 2, 3, 1'b0, 32'h0009_0000, 32'h7000_0800);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        setup(3, 1, 9, 1'b1, 32'h00AA_0000, 32'h7AAA_0000);
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        wait_done("R9");
        repeat (2) @(negedge clk);

        // R10: start held high through a run, new config applied in the done cycle
        cur_req    = "R10";
        rand_ready = 1'b0;
        setup(5, 2, 1, 1'b0, 32'h000B_0000, 32'h7000_0900);
        start = 1'b1;
        @(negedge clk);
        wait_done("R10");
        setup(4, 3, 2, 1'b1, 32'h000C_0000, 32'h7000_0A00);
        @(negedge clk);
        start = 1'b0;
        chk(out_valid === 1'b1, "R10", "back-to-back valid", 64'(out_valid), 64'd1);
        chk(src_addr === 32'h7000_0A00, "R10", "back-to-back first src",
            64'(src_addr), 64'h7000_0A00);
        wait_done("R10");
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule